// File: doc/BRIEF.md
# Histogram-Based DNL Analyzer

This block measures the differential nonlinearity of a converter from a stream of its output codes, taken while a slow linear ramp sweeps the converter's input. Every accepted code adds one hit to its own bin. Once a programmed number of samples has been accepted, the block stops collecting. It then walks the interior codes in ascending order. For each code it reports the hit count, a signed fixed-point DNL value measured against the mean interior occupancy, and a flag that marks codes that were never hit.

A start pulse clears all state and begins a new run. The two end codes gather the ramp's over-range, so they take no part in the mean and are not reported. Each DNL value comes from one sequential divider that serves every bin in turn. When the last interior code has been reported, `done` rises and stays high until the next start.

Top module: `dnl_analyzer`

## Requirements
- R1: Each sample accepted during collection adds one to the bin whose index equals `sampleCode`.
- R2: After a start, exactly `targetCount` samples are accepted. Samples beyond that count are ignored. The report begins once the count is reached, and a target of 0 begins it at once.
- R3: Let S be the sum of the interior bins (codes 1 to 2^CODE_W-2) and N = 2^CODE_W. The DNL of a hit code k is floor(hits[k]*(N-2)*2^FRAC_W / S) - 2^FRAC_W, in two's complement with FRAC_W fractional bits. A code at the mean reads 0, a code above the mean reads positive, and a code below the mean reads negative.
- R4: A code with zero hits reports `outMissing`=1 and a DNL of exactly -2^FRAC_W (-1 LSB). Every other code reports `outMissing`=0.
- R5: When S is 0 (no interior samples, or a target of 0), every interior code is reported as missing.
- R6: A bin stops at 2^CNT_W-1. Further hits on a full bin change neither that bin nor S.
- R7: The report gives one `outValid` pulse per code, for codes 1 through N-2 in ascending order. Codes 0 and N-1 are never reported and never counted in S.
- R8: A start pulse clears all bins and counters, aborts any report in progress and drops `done` on the next cycle.
- R9: Samples that arrive while the block is not collecting (reporting, finished or idle) are ignored.
- R10: `done` rises in the cycle after the last report pulse and stays high, with no further pulses, until the next start.
- R11: After reset, `outValid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears all state and starts collection |
| targetCount | input | SAMP_W | Number of samples to accept; latched at start |
| sampleValid | input | 1 | Marks a valid code on `sampleCode` |
| sampleCode | input | CODE_W | Converter output code |
| outValid | output | 1 | One-cycle strobe for each reported code |
| outCode | output | CODE_W | Index of the reported code |
| outHits | output | CNT_W | Hit count of the reported code |
| outDnl | output | CODE_W+FRAC_W+1 | Signed DNL with FRAC_W fractional bits |
| outMissing | output | 1 | The reported code had zero hits |
| done | output | 1 | The report is complete |

## Verification
On every cycle, the assertions check that reported codes stay inside the interior range, that the missing flag agrees with a zero hit count and forces a DNL of -1 LSB, and that `done` follows the final pulse for code N-2, blocks further pulses and falls after a start. Other behaviour shows only in the bench's scenarios, where outputs are compared with a model that computes the histogram and the quotient arithmetically. That covers the exact DNL values against a non-integer mean, the saturation of one bin and its effect on every other code's DNL, samples ignored beyond the target and during readout, the empty-interior and zero-target cases, and a restart in the middle of a report.

// File: rtl/dnl_pkg.sv
package dnl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_LOAD,
    ST_DIVIDE,
    ST_EMIT,
    ST_DONE
  } dnlState_e;

  typedef struct packed {
    logic clear;
    logic collect;
    logic load;
    logic step;
    logic emit;
  } dnlStrobe_t;

endpackage

// File: rtl/dnl_divider.sv
module dnl_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 20,
  parameter int QW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  input  logic [NUM_W-1:0] numIn,
  input  logic [DEN_W-1:0] den,
  output logic [QW-1:0]    quot
);

  logic [NUM_W-1:0] numSh;
  logic [DEN_W-1:0] rem;
  logic [DEN_W:0]   shifted;
  logic             fits;

  // Restoring long division, one quotient bit per step. The quotient's upper
  // bits are known to be zero, so only QW bits are kept.
  assign shifted = {rem, numSh[NUM_W-1]};
  assign fits    = shifted >= {1'b0, den};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      numSh <= '0;
      rem   <= '0;
      quot  <= '0;
    end else if (load) begin
      numSh <= numIn;
      rem   <= '0;
      quot  <= '0;
    end else if (step) begin
      numSh <= numSh << 1;
      if (fits) begin
        rem  <= DEN_W'(shifted - {1'b0, den});
        quot <= {quot[QW-2:0], 1'b1};
      end else begin
        rem  <= shifted[DEN_W-1:0];
        quot <= {quot[QW-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/dnl_control.sv
module dnl_control
  import dnl_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int STEPS  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              reached,
  output dnlStrobe_t        strb,
  output logic [CODE_W-1:0] binIdx,
  output logic              done
);

  localparam int STEP_W = $clog2(STEPS + 1);
  localparam logic [CODE_W-1:0] FIRST_BIN = CODE_W'(1);
  localparam logic [CODE_W-1:0] LAST_BIN  = {{(CODE_W-1){1'b1}}, 1'b0};

  dnlState_e         state;
  logic [STEP_W-1:0] stepCnt;

  always_comb begin
    strb       = '0;
    strb.clear = start;
    if (!start) begin
      unique case (state)
        ST_COLLECT: strb.collect = 1'b1;
        ST_LOAD:    strb.load    = 1'b1;
        ST_DIVIDE:  strb.step    = 1'b1;
        ST_EMIT:    strb.emit    = 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      binIdx  <= FIRST_BIN;
      stepCnt <= '0;
      done    <= 1'b0;
    end else if (start) begin
      state   <= ST_COLLECT;
      binIdx  <= FIRST_BIN;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_COLLECT: if (reached) state <= ST_LOAD;
        ST_LOAD: begin
          stepCnt <= '0;
          state   <= ST_DIVIDE;
        end
        ST_DIVIDE: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == STEP_W'(STEPS - 1)) state <= ST_EMIT;
        end
        ST_EMIT: begin
          if (binIdx == LAST_BIN) begin
            state <= ST_DONE;
          end else begin
            binIdx <= binIdx + 1'b1;
            state  <= ST_LOAD;
          end
        end
        ST_DONE: done <= 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dnl_datapath.sv
module dnl_datapath
  import dnl_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16,
  parameter int SAMP_W = 20,
  parameter int FRAC_W = 8,
  localparam int DNL_W = CODE_W + FRAC_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dnlStrobe_t              strb,
  input  logic [CODE_W-1:0]       binIdx,
  input  logic [SAMP_W-1:0]       targetCount,
  input  logic                    sampleValid,
  input  logic [CODE_W-1:0]       sampleCode,
  output logic                    reached,
  output logic                    outValid,
  output logic [CODE_W-1:0]       outCode,
  output logic [CNT_W-1:0]        outHits,
  output logic signed [DNL_W-1:0] outDnl,
  output logic                    outMissing
);

  localparam int NBINS = 1 << CODE_W;
  localparam int INNER = NBINS - 2;
  localparam int NUM_W = CNT_W + CODE_W + FRAC_W;
  localparam int QW    = CODE_W + FRAC_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic signed [DNL_W-1:0] ONE = DNL_W'(1 << FRAC_W);

  logic [CNT_W-1:0]  binArr [NBINS];
  logic [CNT_W-1:0]  curHits;
  logic              curSat;
  logic              interiorCode;
  logic              accept;
  logic [SAMP_W-1:0] sampleCnt;
  logic [SAMP_W-1:0] targetReg;
  logic [SAMP_W-1:0] interiorSum;
  logic [CNT_W-1:0]  hitsReg;
  logic [NUM_W-1:0]  numIn;
  logic [QW-1:0]     quot;

  assign curHits      = binArr[sampleCode];
  assign curSat       = curHits == CNT_MAX;
  assign interiorCode = (sampleCode != '0) && (sampleCode != '1);
  assign reached      = sampleCnt == targetReg;
  assign accept       = strb.collect && sampleValid && !reached;

  // One saturating occupancy counter per code.
  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    logic [CNT_W-1:0] binQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        binQ <= '0;
      else if (strb.clear)
        binQ <= '0;
      else if (accept && !curSat && sampleCode == CODE_W'(b))
        binQ <= binQ + 1'b1;
    end
    assign binArr[b] = binQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt   <= '0;
      targetReg   <= '0;
      interiorSum <= '0;
    end else if (strb.clear) begin
      sampleCnt   <= '0;
      targetReg   <= targetCount;
      interiorSum <= '0;
    end else if (accept) begin
      sampleCnt <= sampleCnt + 1'b1;
      if (interiorCode && !curSat) interiorSum <= interiorSum + 1'b1;
    end
  end

  // Scaled numerator hits * (N-2) * 2^FRAC_W for the selected bin.
  assign numIn = (NUM_W'(binArr[binIdx]) * NUM_W'(INNER)) << FRAC_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          hitsReg <= '0;
    else if (strb.load) hitsReg <= binArr[binIdx];
  end

  dnl_divider #(
    .NUM_W(NUM_W),
    .DEN_W(SAMP_W),
    .QW   (QW)
  ) u_div (
    .clk  (clk),
    .rstN (rstN),
    .load (strb.load),
    .step (strb.step),
    .numIn(numIn),
    .den  (interiorSum),
    .quot (quot)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outCode    <= '0;
      outHits    <= '0;
      outDnl     <= '0;
      outMissing <= 1'b0;
    end else begin
      outValid <= strb.emit;
      if (strb.emit) begin
        outCode    <= binIdx;
        outHits    <= hitsReg;
        outMissing <= hitsReg == '0;
        if (hitsReg == '0) outDnl <= -ONE;
        else               outDnl <= $signed({1'b0, quot}) - ONE;
      end
    end
  end

endmodule

// File: rtl/dnl_analyzer.sv
module dnl_analyzer
  import dnl_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16,
  parameter int SAMP_W = 20,
  parameter int FRAC_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [SAMP_W-1:0]              targetCount,
  input  logic                           sampleValid,
  input  logic [CODE_W-1:0]              sampleCode,
  output logic                           outValid,
  output logic [CODE_W-1:0]              outCode,
  output logic [CNT_W-1:0]               outHits,
  output logic signed [CODE_W+FRAC_W:0]  outDnl,
  output logic                           outMissing,
  output logic                           done
);

  localparam int NUM_W = CNT_W + CODE_W + FRAC_W;

  dnlStrobe_t        strb;
  logic [CODE_W-1:0] binIdx;
  logic              reached;

  dnl_control #(
    .CODE_W(CODE_W),
    .STEPS (NUM_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .reached(reached),
    .strb   (strb),
    .binIdx (binIdx),
    .done   (done)
  );

  dnl_datapath #(
    .CODE_W(CODE_W),
    .CNT_W (CNT_W),
    .SAMP_W(SAMP_W),
    .FRAC_W(FRAC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .binIdx     (binIdx),
    .targetCount(targetCount),
    .sampleValid(sampleValid),
    .sampleCode (sampleCode),
    .reached    (reached),
    .outValid   (outValid),
    .outCode    (outCode),
    .outHits    (outHits),
    .outDnl     (outDnl),
    .outMissing (outMissing)
  );

endmodule

// File: rtl/dnl_analyzer_chk.sv
module dnl_analyzer_chk #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          start,
  input logic                          outValid,
  input logic [CODE_W-1:0]             outCode,
  input logic [CNT_W-1:0]              outHits,
  input logic signed [CODE_W+FRAC_W:0] outDnl,
  input logic                          outMissing,
  input logic                          done
);

  localparam int ONE = 1 << FRAC_W;
  localparam logic [CODE_W-1:0] LAST_BIN = {{(CODE_W-1){1'b1}}, 1'b0};

  a_r7_interior_only: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCode != '0) && (outCode != '1));

  a_r4_missing_flag: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outMissing == (outHits == '0)));

  a_r4_missing_value: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMissing) |-> ($signed(outDnl) == -ONE));

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(outValid) && $past(outCode) == LAST_BIN));

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);

  a_r8_start_drops_done: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);

endmodule

bind dnl_analyzer dnl_analyzer_chk #(
  .CODE_W(CODE_W),
  .CNT_W (CNT_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .outValid  (outValid),
  .outCode   (outCode),
  .outHits   (outHits),
  .outDnl    (outDnl),
  .outMissing(outMissing),
  .done      (done)
);

// File: tb/dnl_analyzer_test.sv
module dnl_analyzer_test;

  localparam int CODE_W = 4;
  localparam int CNT_W  = 8;
  localparam int SAMP_W = 16;
  localparam int FRAC_W = 8;
  localparam int NB     = 1 << CODE_W;
  localparam int INNER  = NB - 2;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic                          clk = 1'b0;
  logic                          rstN = 1'b0;
  logic                          start = 1'b0;
  logic [SAMP_W-1:0]             targetCount = '0;
  logic                          sampleValid = 1'b0;
  logic [CODE_W-1:0]             sampleCode = '0;
  logic                          outValid;
  logic [CODE_W-1:0]             outCode;
  logic [CNT_W-1:0]              outHits;
  logic signed [CODE_W+FRAC_W:0] outDnl;
  logic                          outMissing;
  logic                          done;

  int errors = 0;
  int checks = 0;
  int model [NB];
  int accepted = 0;
  int target = 0;

  always #2.5 clk = ~clk;

  dnl_analyzer #(
    .CODE_W(CODE_W),
    .CNT_W (CNT_W),
    .SAMP_W(SAMP_W),
    .FRAC_W(FRAC_W)
  ) uut (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .targetCount(targetCount),
    .sampleValid(sampleValid),
    .sampleCode (sampleCode),
    .outValid   (outValid),
    .outCode    (outCode),
    .outHits    (outHits),
    .outDnl     (outDnl),
    .outMissing (outMissing),
    .done       (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doStart(input int tgt);
    @(negedge clk);
    start = 1'b1;
    targetCount = SAMP_W'(tgt);
    sampleValid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    target = tgt;
    accepted = 0;
    for (int i = 0; i < NB; i++) model[i] = 0;
  endtask

  // Drives one code per cycle; the model accepts only up to the target.
  task automatic pushCode(input int code, input int reps);
    for (int i = 0; i < reps; i++) begin
      sampleValid = 1'b1;
      sampleCode = CODE_W'(code);
      if (accepted < target) begin
        accepted++;
        if (model[code] < CMAX) model[code]++;
      end
      @(negedge clk);
    end
    sampleValid = 1'b0;
  endtask

  // Reads the whole report while feeding samples that must be ignored (R9).
  task automatic runReport(input string hitTag);
    int idx = 1;
    int guard = 0;
    longint sum = 0;
    for (int k = 1; k <= INNER; k++) sum += model[k];
    while (done !== 1'b1 && guard < 20000) begin
      @(negedge clk);
      if (outValid === 1'b1) begin
        longint expDnl;
        bit expMiss;
        if (idx <= INNER) begin
          expMiss = model[idx] == 0;
          expDnl = expMiss ? -(1 << FRAC_W)
                           : (longint'(model[idx]) * INNER * (1 << FRAC_W)) / sum - (1 << FRAC_W);
          check(int'(outCode) == idx, "R7 code order", int'(outCode), idx);
          check(int'(outHits) == model[idx], {hitTag, "/R9 hits"}, int'(outHits), model[idx]);
          check(outMissing == expMiss, "R4 missing flag", int'(outMissing), int'(expMiss));
          check(int'($signed(outDnl)) == int'(expDnl), "R3 dnl value",
                int'($signed(outDnl)), int'(expDnl));
        end
        idx++;
      end
      sampleValid = 1'b1;
      sampleCode = CODE_W'(5);
      guard++;
    end
    sampleValid = 1'b0;
    check(idx - 1 == INNER, "R7 report count", idx - 1, INNER);
    check(done === 1'b1, "R10 done raised", int'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int quietBad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R11 outValid after reset", int'(outValid), 0);
    check(done === 1'b0, "R11 done after reset", int'(done), 0);

    // Uniform ramp: every code equals the mean, DNL 0 (R1, R3).
    doStart(48);
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < NB; c++) pushCode(c, 1);
    runReport("R1");

    // done holds with no pulses and stray samples change nothing (R10).
    quietBad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      if (done !== 1'b1 || outValid !== 1'b0) quietBad++;
    end
    sampleValid = 1'b0;
    check(quietBad == 0, "R10 done holds quietly", quietBad, 0);

    // Uneven occupancy with missing codes, plus samples beyond the target (R2).
    begin
      int tot = 20;
      for (int k = 1; k <= INNER; k++) tot += k % 4 + ((k % 4 == 0) ? 0 : 1);
      doStart(tot);
      pushCode(0, 10);
      for (int k = 1; k <= INNER; k++)
        if (k % 4 != 0) pushCode(k, k % 4 + 1);
      pushCode(NB - 1, 10);
      pushCode(7, 20);
      runReport("R2");
    end

    // One saturated bin skews every DNL (R6).
    doStart(345);
    pushCode(3, 300);
    pushCode(9, 40);
    pushCode(0, 5);
    runReport("R6");

    // Only end codes hit: interior all missing (R5).
    doStart(20);
    pushCode(0, 10);
    pushCode(NB - 1, 10);
    runReport("R5");

    // Zero target: report immediately, all missing (R5).
    doStart(0);
    pushCode(6, 4);
    runReport("R5");

    // Restart in the middle of a report; the new run starts clean (R8).
    doStart(30);
    pushCode(4, 30);
    begin
      int seen = 0;
      int guard = 0;
      while (seen < 3 && guard < 5000) begin
        @(negedge clk);
        if (outValid === 1'b1) seen++;
        guard++;
      end
    end
    doStart(28);
    check(done === 1'b0, "R8 done low after start", int'(done), 0);
    for (int k = 1; k <= INNER; k++) pushCode(k, 2);
    runReport("R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule